// File: doc/BRIEF.md
# In-Order Retirement Buffer

This block lets work that finishes out of order leave in the order it was started. Before starting a job, a requester takes a token from the allocation port. The token is the index of a slot in an internal ring. When the job finishes, the requester writes its result through the write port, tagged with that token. Results can come back in any order. The read port shows a result only when the oldest outstanding token has been written. It then releases results one per accepted read, in the same order the tokens were handed out.

Three state elements track the ring:

- the next token to issue,
- the oldest outstanding slot,
- the number of outstanding tokens.

Both indices wrap modulo the slot count, which must be a power of two. Taking a token clears that slot's valid flag, so a reused slot never shows stale data. Writing a result sets the flag. Allocation is refused while every slot is outstanding.

Top module: `inorder_retire_buf`

## Requirements
- R1: After reset, `alloc_rdy` is 1, `alloc_tok` is 0 and `rd_vld` is 0.
- R2: Each accepted allocation (`alloc_req` and `alloc_rdy` both high at a clock edge) advances `alloc_tok` by one modulo SLOTS. With no accepted allocation, `alloc_tok` holds its value.
- R3: While SLOTS tokens are outstanding, `alloc_rdy` is 0. An `alloc_req` in that state has no effect: `alloc_tok` keeps its value.
- R4: The value on `rd_data` while `rd_vld` is high equals the `wr_data` last written with the token of the oldest outstanding slot.
- R5: `rd_vld` is high exactly when at least one token is outstanding and the oldest one has been written. Results leave in allocation order, whatever the order of the writes.
- R6: With no token outstanding, `rd_vld` is 0.
- R7: An accepted allocation and an accepted read in the same cycle leave the number of outstanding tokens unchanged. So `alloc_rdy` stays 1 when SLOTS-1 tokens were outstanding.
- R8: A write to one slot and a read of another slot in the same cycle both take effect.
- R9: When a slot is reissued after the ring wraps, it counts as unwritten. `rd_vld` stays 0 for it until a new write arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Request for a new token |
| alloc_rdy | output | 1 | A token can be issued this cycle |
| alloc_tok | output | $clog2(SLOTS) | Token issued on an accepted allocation |
| wr_vld | input | 1 | Result write strobe |
| wr_tok | input | $clog2(SLOTS) | Token that the written result belongs to |
| wr_data | input | DATA_W | Result value |
| rd_vld | output | 1 | Oldest outstanding result is available |
| rd_rdy | input | 1 | Consumer accepts the result shown |
| rd_data | output | DATA_W | Oldest outstanding result |

## Verification
The assertions assume that each issued token is written at most once before it is read. They also assume that writes name only tokens that are currently outstanding and not the one being issued in the same cycle. Under these assumptions a displayed result stays stable until it is taken.

The random stimulus stays within these rules. It picks write tokens only from the bench's own list of outstanding, unwritten tokens. It also holds `alloc_req` low during reset.

// File: rtl/retire_buf_pkg.sv
package retire_buf_pkg;

    typedef enum logic [1:0] {
        OCC_HOLD = 2'b00,
        OCC_INC  = 2'b01,
        OCC_DEC  = 2'b10,
        OCC_SWAP = 2'b11
    } occ_op_e;

    function automatic occ_op_e occ_op(input logic take, input logic give);
        occ_op = occ_op_e'({give, take});
    endfunction

endpackage

// File: rtl/retire_ptr_ctrl.sv
module retire_ptr_ctrl
    import retire_buf_pkg::*;
#(
    parameter int SLOTS = 8,
    localparam int IDX_W = $clog2(SLOTS),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_en,
    input  logic             give_en,
    output logic [IDX_W-1:0] in_idx,
    output logic [IDX_W-1:0] out_idx,
    output logic             full,
    output logic             empty
);

    typedef struct packed {
        logic [IDX_W-1:0] in_idx;
        logic [IDX_W-1:0] out_idx;
        logic [CNT_W-1:0] count;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    occ_op_e    op;

    always_comb begin
        st_d = st_q;
        op   = occ_op(take_en, give_en);
        if (take_en) begin
            st_d.in_idx = st_q.in_idx + 1'b1;
        end
        if (give_en) begin
            st_d.out_idx = st_q.out_idx + 1'b1;
        end
        case (op)
            OCC_INC:  st_d.count = st_q.count + 1'b1;
            OCC_DEC:  st_d.count = st_q.count - 1'b1;
            default:  st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_idx  = st_q.in_idx;
    assign out_idx = st_q.out_idx;
    assign full    = (st_q.count == CNT_W'(SLOTS));
    assign empty   = (st_q.count == '0);

endmodule

// File: rtl/retire_slot_store.sv
module retire_slot_store #(
    parameter int SLOTS  = 8,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic [DATA_W-1:0] set_data,
    input  logic [IDX_W-1:0]  head_idx,
    output logic              head_valid,
    output logic [DATA_W-1:0] head_data
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] dat;
    } slot_t;

    slot_t             slot_d [SLOTS];
    slot_t             slot_q [SLOTS];
    logic [SLOTS-1:0]  hit_clr;
    logic [SLOTS-1:0]  hit_set;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot_dec
        assign hit_clr[g] = clr_en && (clr_idx == IDX_W'(g));
        assign hit_set[g] = set_en && (set_idx == IDX_W'(g));
    end

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            slot_d[i] = slot_q[i];
            if (hit_clr[i]) begin
                slot_d[i].vld = 1'b0;
            end
            if (hit_set[i]) begin
                slot_d[i].vld = 1'b1;
                slot_d[i].dat = set_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                slot_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                slot_q[i] <= slot_d[i];
            end
        end
    end

    assign head_valid = slot_q[head_idx].vld;
    assign head_data  = slot_q[head_idx].dat;

endmodule

// File: rtl/inorder_retire_buf.sv
module inorder_retire_buf #(
    parameter int SLOTS  = 8,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    output logic              alloc_rdy,
    output logic [IDX_W-1:0]  alloc_tok,
    input  logic              wr_vld,
    input  logic [IDX_W-1:0]  wr_tok,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rd_vld,
    input  logic              rd_rdy,
    output logic [DATA_W-1:0] rd_data
);

    logic             alloc_fire;
    logic             rd_fire;
    logic [IDX_W-1:0] in_idx;
    logic [IDX_W-1:0] out_idx;
    logic             ring_full;
    logic             ring_empty;
    logic             head_valid;

    retire_ptr_ctrl #(.SLOTS(SLOTS)) ptr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_en (alloc_fire),
        .give_en (rd_fire),
        .in_idx  (in_idx),
        .out_idx (out_idx),
        .full    (ring_full),
        .empty   (ring_empty)
    );

    retire_slot_store #(.SLOTS(SLOTS), .DATA_W(DATA_W)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_en     (alloc_fire),
        .clr_idx    (in_idx),
        .set_en     (wr_vld),
        .set_idx    (wr_tok),
        .set_data   (wr_data),
        .head_idx   (out_idx),
        .head_valid (head_valid),
        .head_data  (rd_data)
    );

    assign alloc_rdy  = !ring_full;
    assign alloc_tok  = in_idx;
    assign alloc_fire = alloc_req && alloc_rdy;
    assign rd_vld     = !ring_empty && head_valid;
    assign rd_fire    = rd_vld && rd_rdy;

endmodule

// File: rtl/retire_buf_chk.sv
module retire_buf_chk #(
    parameter int SLOTS  = 8,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(SLOTS),
    localparam int CNT_W = IDX_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alloc_req,
    input logic              alloc_rdy,
    input logic [IDX_W-1:0]  alloc_tok,
    input logic              rd_vld,
    input logic              rd_rdy,
    input logic [DATA_W-1:0] rd_data
);

    logic             take;
    logic             give;
    logic [CNT_W-1:0] occ_q;

    assign take = alloc_req && alloc_rdy;
    assign give = rd_vld && rd_rdy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_q + CNT_W'(take) - CNT_W'(give);
        end
    end

    // R2
    a_r2_tok_step: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> alloc_tok == IDX_W'($past(alloc_tok) + 1'b1));

    // R2
    a_r2_tok_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(alloc_tok));

    // R3
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == CNT_W'(SLOTS)) |-> !alloc_rdy);

    // R6
    a_r6_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == '0) |-> !rd_vld);

    // R4
    a_r4_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld && !rd_rdy) |=> (rd_vld && $stable(rd_data)));

    // R7
    a_r7_room_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (take && give) |=> alloc_rdy);

endmodule

bind inorder_retire_buf retire_buf_chk #(.SLOTS(SLOTS), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_req (alloc_req),
    .alloc_rdy (alloc_rdy),
    .alloc_tok (alloc_tok),
    .rd_vld    (rd_vld),
    .rd_rdy    (rd_rdy),
    .rd_data   (rd_data)
);

// File: tb/inorder_retire_buf_tb_top.sv
module inorder_retire_buf_tb_top;

    localparam int SLOTS  = 8;
    localparam int DATA_W = 16;
    localparam int IW     = $clog2(SLOTS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alloc_req = 1'b0;
    logic              alloc_rdy;
    logic [IW-1:0]     alloc_tok;
    logic              wr_vld = 1'b0;
    logic [IW-1:0]     wr_tok = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_vld;
    logic              rd_rdy = 1'b0;
    logic [DATA_W-1:0] rd_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // reference state, derived from the requirements
    int                m_head = 0;
    int                m_tail = 0;
    int                m_occ  = 0;
    bit                m_wr  [SLOTS];
    logic [DATA_W-1:0] m_dat [SLOTS];

    always #10 clk = ~clk;

    inorder_retire_buf #(.SLOTS(SLOTS), .DATA_W(DATA_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_req (alloc_req),
        .alloc_rdy (alloc_rdy),
        .alloc_tok (alloc_tok),
        .wr_vld    (wr_vld),
        .wr_tok    (wr_tok),
        .wr_data   (wr_data),
        .rd_vld    (rd_vld),
        .rd_rdy    (rd_rdy),
        .rd_data   (rd_data)
    );

    function automatic bit exp_rdy();
        return m_occ < SLOTS;
    endfunction

    function automatic bit exp_vld();
        return (m_occ > 0) && m_wr[m_head];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // compare outputs at the falling edge, then drive the next cycle's inputs
    task automatic step(input bit a, input bit w, input int wt,
                        input logic [DATA_W-1:0] wd, input bit r, input string req);
        bit af, rf;
        @(negedge clk);
        chk(alloc_rdy == exp_rdy(), req, "alloc_rdy", int'(alloc_rdy), int'(exp_rdy()));
        chk(int'(alloc_tok) == m_tail, req, "alloc_tok", int'(alloc_tok), m_tail);
        chk(rd_vld == exp_vld(), req, "rd_vld", int'(rd_vld), int'(exp_vld()));
        if (exp_vld() && rd_vld) begin
            chk(rd_data == m_dat[m_head], req, "rd_data",
                int'(rd_data), int'(m_dat[m_head]));
        end
        alloc_req = a;
        wr_vld    = w;
        wr_tok    = IW'(wt);
        wr_data   = wd;
        rd_rdy    = r;
        af = a && exp_rdy();
        rf = r && exp_vld();
        if (w) begin
            m_wr[wt]  = 1'b1;
            m_dat[wt] = wd;
        end
        if (af) begin
            m_wr[m_tail] = 1'b0;
            m_tail = (m_tail + 1) % SLOTS;
        end
        if (rf) begin
            m_head = (m_head + 1) % SLOTS;
        end
        m_occ = m_occ + int'(af) - int'(rf);
    endtask

    task automatic idle(input string req);
        step(1'b0, 1'b0, 0, '0, 1'b0, req);
    endtask

    task automatic drain(input string req);
        while (m_occ > 0) begin
            step(1'b0, !m_wr[m_head], m_head, 16'h5000 + 16'(m_head), 1'b1, req);
        end
        idle(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < SLOTS; i++) begin
            m_wr[i]  = 1'b0;
            m_dat[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(alloc_rdy == 1'b1, "R1", "alloc_rdy in reset", int'(alloc_rdy), 1);
        chk(alloc_tok == '0, "R1", "alloc_tok in reset", int'(alloc_tok), 0);
        chk(rd_vld == 1'b0, "R1", "rd_vld in reset", int'(rd_vld), 0);
        rst_n = 1'b1;
        idle("R1");

        // R2 and R3: fill the ring, then request while full
        for (int i = 0; i < SLOTS; i++) step(1'b1, 1'b0, 0, '0, 1'b0, "R2");
        step(1'b1, 1'b0, 0, '0, 1'b0, "R3");
        step(1'b1, 1'b0, 0, '0, 1'b0, "R3");
        idle("R3");

        // R5: write in reverse order, nothing leaves until the oldest arrives
        for (int t = SLOTS - 1; t >= 1; t--) begin
            step(1'b0, 1'b1, t, 16'h1000 + 16'(t), 1'b1, "R5");
        end
        step(1'b0, 1'b1, 0, 16'h1000, 1'b1, "R5");
        drain("R4");
        idle("R6");

        // R7: SLOTS-1 outstanding, allocate and read in one cycle
        for (int i = 0; i < SLOTS - 1; i++) step(1'b1, 1'b0, 0, '0, 1'b0, "R7");
        step(1'b0, 1'b1, m_head, 16'h2222, 1'b0, "R7");
        step(1'b1, 1'b0, 0, '0, 1'b1, "R7");
        idle("R7");

        // R8: write a younger slot while the head leaves
        step(1'b0, 1'b1, m_head, 16'h3333, 1'b0, "R8");
        step(1'b0, 1'b1, (m_head + 1) % SLOTS, 16'h4444, 1'b1, "R8");
        idle("R8");
        drain("R8");

        // R9: a reissued slot must not show its old data
        step(1'b1, 1'b0, 0, '0, 1'b0, "R9");
        idle("R9");
        idle("R9");
        drain("R9");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            bit a, w, r;
            int wt;
            a  = ($urandom % 3) != 0;
            r  = ($urandom % 4) != 0;
            w  = 1'b0;
            wt = 0;
            if (m_occ > 0 && ($urandom % 2) == 1) begin
                int k;
                k = $urandom % m_occ;
                for (int j = 0; j < m_occ; j++) begin
                    int s;
                    s = (m_head + (k + j) % m_occ) % SLOTS;
                    if (!w && !m_wr[s]) begin
                        w  = 1'b1;
                        wt = s;
                    end
                end
            end
            step(a, w, wt, 16'($urandom), r, "R5");
        end
        drain("R4");

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule